// File: doc/BRIEF.md
# Waveform Timer Channel

This block is a single timer channel that generates two output waveforms, A and B, from one up or up/down counter and three compare values. Counting advances only on cycles where the prescaled `tick` input is high. The counter can reload itself on a match with the third compare value, or turn around there. Each output moves on its own compare, on the shared compare, on an external event and on a software trigger. Each source has its own action: leave, set, clear or toggle.

Software drives the channel through a small synchronous register port. Offset 0 takes write-one commands and reads back the counter. Offset 1 holds the mode word. Offsets 2, 3 and 4 hold compare values RA, RB and RC. Offset 5 is status and clears when read. Offset 6 enables interrupts on write and reads back the mask. Offset 7 disables interrupts on write. The external event is picked from the B pin input or from one of three external clock lines. It can also act as a trigger that restarts the count.

Mode word layout: [1:0] counting mode, [2] stop on RC match, [3] clock-off on RC match, [5:4] event edge, [7:6] event source, [8] event acts as trigger, [10:9] A on RA, [12:11] A on RC, [14:13] A on event, [16:15] A on software trigger, [18:17] B on RB, [20:19] B on RC, [22:21] B on event, [24:23] B on software trigger.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset, outA, outB and irq are low, the counter reads 0, the status and the interrupt mask read 0, and the clock-enabled status bit is clear.
- R2: In counting mode 0 the counter rises by one on each tick while the clock is enabled. It wraps from its maximum value to 0. Overflow status bit 0 is set whenever a counting tick finds the counter at its maximum while counting upward.
- R3: In counting mode 2 a match with RC causes a reload to 0 on the next tick, giving a period of RC+1 ticks.
- R4: In counting mode 1 the counter runs up to its maximum, then down to 0, then up again. Mode 3 does the same with RC (RC of at least 1) as the turning point.
- R5: Command bits at offset 0 are write-one: bit 0 enables the clock, bit 1 disables it and wins over bit 0, and bit 2 is a software trigger. Any trigger zeroes the counter on the next tick, not before.
- R6: With mode bit 2, an RC match freezes the counter while the clock stays enabled, until a trigger. With mode bit 3, an RC match clears the clock enable, and a later enable command resumes counting from the held value.
- R7: Output actions use the code 0 none, 1 set, 2 clear, 3 toggle. A reacts to RA and RC matches, B reacts to RB and RC matches, and both react to the event and the software trigger. A match counts when the counter takes the compare value.
- R8: The event source is 0 B pin, 1/2/3 external lines 0/1/2. The edge is 0 none, 1 rising, 2 falling, 3 both. A detected event sets status bit 7. With mode bit 8 set it also acts as a trigger.
- R9: When several sources with a non-zero action hit one output in the same cycle, the software trigger wins, then the event, then the RC match, then the RA or RB match.
- R10: Status bits 0, 2, 3, 4 and 7 (overflow, RA, RB, RC match, event) stay set until status is read. Bits 16, 17 and 18 show the clock enable, outA and outB live.
- R11: Writing ones at offset 6 sets interrupt mask bits, and writing ones at offset 7 clears them. Offset 6 reads the mask. irq is high when any set status flag has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| xcIn | input | 3 | External clock/event lines |
| pinBIn | input | 1 | B pin input used as event source 0 |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears status at offset 5) |
| regAddr | input | 3 | Register offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| outA | output | 1 | Waveform A |
| outB | output | 1 | Waveform B |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with a 6-bit counter, so wrap, overflow and full up/down cycles take fewer than 130 ticks. Every counter value in each of the four counting modes is compared against a closed-form sequence. Every pair of event source and edge setting is swept against the expected toggle count on B. Same-cycle collisions of the software trigger, the event and the compare matches are set up on purpose to exercise the priority order.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  localparam int REG_DW = 32;

  typedef enum logic [1:0] {
    CM_UP      = 2'd0,
    CM_UPDN    = 2'd1,
    CM_UP_RC   = 2'd2,
    CM_UPDN_RC = 2'd3
  } cmode_e;

  localparam logic [1:0] ACT_NONE = 2'd0;
  localparam logic [1:0] ACT_SET  = 2'd1;
  localparam logic [1:0] ACT_CLR  = 2'd2;
  localparam logic [1:0] ACT_TGL  = 2'd3;

  // declared MSB first
  typedef struct packed {
    logic [1:0] bSw;
    logic [1:0] bEv;
    logic [1:0] bRc;
    logic [1:0] bRb;
    logic [1:0] aSw;
    logic [1:0] aEv;
    logic [1:0] aRc;
    logic [1:0] aRa;
    logic       evTrig;
    logic [1:0] evSrc;
    logic [1:0] evEdge;
    logic       disOnRc;
    logic       stopOnRc;
    cmode_e     waveMode;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef struct packed {
    logic swTrig;
    logic extEv;
    logic clkOn;
    logic clkOff;
  } strobe_t;

  typedef struct packed {
    logic ovf;
    logic cmpA;
    logic cmpB;
    logic cmpC;
  } hit_t;

  localparam logic [2:0] ADR_CMD  = 3'd0;
  localparam logic [2:0] ADR_MODE = 3'd1;
  localparam logic [2:0] ADR_RA   = 3'd2;
  localparam logic [2:0] ADR_RB   = 3'd3;
  localparam logic [2:0] ADR_RC   = 3'd4;
  localparam logic [2:0] ADR_STAT = 3'd5;
  localparam logic [2:0] ADR_IEN  = 3'd6;
  localparam logic [2:0] ADR_IDIS = 3'd7;

  localparam int ST_OVF = 0;
  localparam int ST_CPA = 2;
  localparam int ST_CPB = 3;
  localparam int ST_CPC = 4;
  localparam int ST_EXT = 7;
  localparam int ST_CLK = 16;
  localparam int ST_MA  = 17;
  localparam int ST_MB  = 18;
  localparam logic [7:0] FLAG_MASK = 8'b1001_1101;

  function automatic logic applyAct(input logic cur, input logic [1:0] act);
    case (act)
      ACT_SET: applyAct = 1'b1;
      ACT_CLR: applyAct = 1'b0;
      ACT_TGL: applyAct = ~cur;
      default: applyAct = cur;
    endcase
  endfunction

  // highest-priority source with a non-zero action wins
  function automatic logic [1:0] pickAct(
    input logic evSw, input logic [1:0] actSw,
    input logic evEx, input logic [1:0] actEx,
    input logic evRc, input logic [1:0] actRc,
    input logic evCm, input logic [1:0] actCm);
    if (evSw && actSw != ACT_NONE)      pickAct = actSw;
    else if (evEx && actEx != ACT_NONE) pickAct = actEx;
    else if (evRc && actRc != ACT_NONE) pickAct = actRc;
    else if (evCm)                      pickAct = actCm;
    else                                pickAct = ACT_NONE;
  endfunction
endpackage

// File: rtl/wtc_ctrl.sv
`timescale 1ns/1ps
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  input  logic [2:0]        xcIn,
  input  logic              pinBIn,
  input  hit_t              hits,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              clkEn,
  input  logic              outA,
  input  logic              outB,
  output mode_t             modeQ,
  output logic [CNT_W-1:0]  raQ,
  output logic [CNT_W-1:0]  rbQ,
  output logic [CNT_W-1:0]  rcQ,
  output strobe_t           strb,
  output logic              irq
);
  localparam int PAD_CNT  = REG_DW - CNT_W;
  localparam int PAD_MODE = REG_DW - MODE_W;

  logic       evSel, evPrevQ, evHit, evRise, evFall;
  logic       cmdWr, rdClr;
  logic [7:0] stickyQ, maskQ, newBits;
  logic [REG_DW-1:0] statWord;
  logic       unusedWdata;

  assign unusedWdata = ^regWdata;

  // event source and edge
  always_comb begin
    case (modeQ.evSrc)
      2'd0:    evSel = pinBIn;
      2'd1:    evSel = xcIn[0];
      2'd2:    evSel = xcIn[1];
      default: evSel = xcIn[2];
    endcase
  end

  assign evRise = evSel & ~evPrevQ;
  assign evFall = ~evSel & evPrevQ;

  always_comb begin
    case (modeQ.evEdge)
      2'd0:    evHit = 1'b0;
      2'd1:    evHit = evRise;
      2'd2:    evHit = evFall;
      default: evHit = evRise | evFall;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evPrevQ <= 1'b0;
    else       evPrevQ <= evSel;
  end

  // command strobes
  assign cmdWr       = regWr && (regAddr == ADR_CMD);
  assign strb.clkOn  = cmdWr & regWdata[0];
  assign strb.clkOff = cmdWr & regWdata[1];
  assign strb.swTrig = cmdWr & regWdata[2];
  assign strb.extEv  = evHit;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      raQ   <= '0;
      rbQ   <= '0;
      rcQ   <= '0;
    end else if (regWr) begin
      case (regAddr)
        ADR_MODE: modeQ <= mode_t'(regWdata[MODE_W-1:0]);
        ADR_RA:   raQ   <= regWdata[CNT_W-1:0];
        ADR_RB:   rbQ   <= regWdata[CNT_W-1:0];
        ADR_RC:   rcQ   <= regWdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // sticky status and interrupt mask
  always_comb begin
    newBits         = '0;
    newBits[ST_OVF] = hits.ovf;
    newBits[ST_CPA] = hits.cmpA;
    newBits[ST_CPB] = hits.cmpB;
    newBits[ST_CPC] = hits.cmpC;
    newBits[ST_EXT] = evHit;
  end

  assign rdClr = regRd && (regAddr == ADR_STAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= '0;
      maskQ   <= '0;
    end else begin
      stickyQ <= rdClr ? newBits : (stickyQ | newBits);
      if (regWr && regAddr == ADR_IEN)
        maskQ <= maskQ | (regWdata[7:0] & FLAG_MASK);
      else if (regWr && regAddr == ADR_IDIS)
        maskQ <= maskQ & ~regWdata[7:0];
    end
  end

  assign irq = |(stickyQ & maskQ);

  always_comb begin
    statWord         = '0;
    statWord[7:0]    = stickyQ;
    statWord[ST_CLK] = clkEn;
    statWord[ST_MA]  = outA;
    statWord[ST_MB]  = outB;
  end

  always_comb begin
    case (regAddr)
      ADR_CMD:  regRdata = {{PAD_CNT{1'b0}}, cnt};
      ADR_MODE: regRdata = {{PAD_MODE{1'b0}}, modeQ};
      ADR_RA:   regRdata = {{PAD_CNT{1'b0}}, raQ};
      ADR_RB:   regRdata = {{PAD_CNT{1'b0}}, rbQ};
      ADR_RC:   regRdata = {{PAD_CNT{1'b0}}, rcQ};
      ADR_STAT: regRdata = statWord;
      ADR_IEN:  regRdata = {{(REG_DW-8){1'b0}}, maskQ};
      default:  regRdata = '0;
    endcase
  end

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdClr && newBits == 8'd0) |=> (stickyQ == 8'd0));

  a_r11_mask_off: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADR_IDIS && (&regWdata[7:0])) |=> !irq);
endmodule

// File: rtl/wtc_datapath.sv
`timescale 1ns/1ps
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  mode_t            modeQ,
  input  logic [CNT_W-1:0] raQ,
  input  logic [CNT_W-1:0] rbQ,
  input  logic [CNT_W-1:0] rcQ,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] cnt,
  output logic             clkEn,
  output logic             outA,
  output logic             outB,
  output hit_t             hits
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ, cntNxt, cntNew, topVal;
  logic upQ, upNxt, stopQ, pendQ, clkEnQ, outAQ, outBQ;
  logic run, load, upd, trigAny, autoTrig, evAnyA;
  logic [1:0] actA, actB;
  logic unusedMode;

  assign unusedMode = ^{modeQ.evEdge, modeQ.evSrc};

  assign run  = tick & clkEnQ & ~stopQ & ~pendQ;
  assign load = tick & pendQ;
  assign upd  = run | load;

  assign topVal = (modeQ.waveMode == CM_UPDN_RC) ? rcQ : CNT_MAX;

  // next count for a counting tick
  always_comb begin
    cntNxt = cntQ + CNT_ONE;
    upNxt  = 1'b1;
    if (modeQ.waveMode == CM_UPDN || modeQ.waveMode == CM_UPDN_RC) begin
      if (upQ) begin
        if (cntQ >= topVal) begin
          cntNxt = cntQ - CNT_ONE;
          upNxt  = 1'b0;
        end
      end else if (cntQ == '0) begin
        cntNxt = CNT_ONE;
      end else begin
        cntNxt = cntQ - CNT_ONE;
        upNxt  = 1'b0;
      end
    end
  end

  assign cntNew = load ? '0 : (run ? cntNxt : cntQ);

  assign hits.cmpA = upd && (cntNew == raQ);
  assign hits.cmpB = upd && (cntNew == rbQ);
  assign hits.cmpC = upd && (cntNew == rcQ);
  assign hits.ovf  = run && upQ && (cntQ == CNT_MAX);

  assign autoTrig = (modeQ.waveMode == CM_UP_RC) && hits.cmpC;
  assign trigAny  = strb.swTrig | (strb.extEv & modeQ.evTrig) | autoTrig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      upQ    <= 1'b1;
      stopQ  <= 1'b0;
      pendQ  <= 1'b0;
      clkEnQ <= 1'b0;
    end else begin
      cntQ  <= cntNew;
      pendQ <= (pendQ & ~tick) | trigAny;
      if (load)     upQ <= 1'b1;
      else if (run) upQ <= upNxt;
      if (hits.cmpC && modeQ.stopOnRc) stopQ <= 1'b1;
      else if (load)                   stopQ <= 1'b0;
      if (strb.clkOff || (hits.cmpC && modeQ.disOnRc)) clkEnQ <= 1'b0;
      else if (strb.clkOn)                             clkEnQ <= 1'b1;
    end
  end

  // output actions
  assign actA = pickAct(strb.swTrig, modeQ.aSw, strb.extEv, modeQ.aEv,
                        hits.cmpC, modeQ.aRc, hits.cmpA, modeQ.aRa);
  assign actB = pickAct(strb.swTrig, modeQ.bSw, strb.extEv, modeQ.bEv,
                        hits.cmpC, modeQ.bRc, hits.cmpB, modeQ.bRb);
  assign evAnyA = strb.swTrig | strb.extEv | hits.cmpC | hits.cmpA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAQ <= 1'b0;
      outBQ <= 1'b0;
    end else begin
      outAQ <= applyAct(outAQ, actA);
      outBQ <= applyAct(outBQ, actB);
    end
  end

  assign cnt   = cntQ;
  assign clkEn = clkEnQ;
  assign outA  = outAQ;
  assign outB  = outBQ;

  a_r5_off_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.clkOff |=> !clkEnQ);

  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && !pendQ) |=> $stable(cntQ));

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (run && modeQ.waveMode == CM_UP && cntQ == CNT_MAX) |=> (cntQ == '0));

  a_r7_outa_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !evAnyA |=> $stable(outAQ));

  a_r9_sw_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swTrig && modeQ.aSw == ACT_SET) |=> outAQ);
endmodule

// File: rtl/wave_timer_chan.sv
`timescale 1ns/1ps
module wave_timer_chan
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic [2:0]  xcIn,
  input  logic        pinBIn,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        outA,
  output logic        outB,
  output logic        irq
);
  mode_t            modeQ;
  strobe_t          strb;
  hit_t             hits;
  logic [CNT_W-1:0] raQ, rbQ, rcQ, cnt;
  logic             clkEn;

  wtc_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .xcIn(xcIn), .pinBIn(pinBIn),
    .hits(hits), .cnt(cnt), .clkEn(clkEn), .outA(outA), .outB(outB),
    .modeQ(modeQ), .raQ(raQ), .rbQ(rbQ), .rcQ(rcQ), .strb(strb), .irq(irq)
  );

  wtc_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .modeQ(modeQ), .raQ(raQ), .rbQ(rbQ),
    .rcQ(rcQ), .strb(strb), .cnt(cnt), .clkEn(clkEn), .outA(outA),
    .outB(outB), .hits(hits)
  );
endmodule

// File: tb/sim_wave_timer_chan.sv
`timescale 1ns/1ps
module sim_wave_timer_chan;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  xcIn = 3'b000;
  logic        pinBIn = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        outA, outB, irq;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wave_timer_chan #(.CNT_W(6)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .xcIn(xcIn), .pinBIn(pinBIn),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .outA(outA), .outB(outB), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int adr, input int dat);
    regAddr = adr[2:0];
    regWdata = dat;
    regWr = 1'b1;
    step();
    regWr = 1'b0;
  endtask

  task automatic peek(input int adr, output int val);
    regAddr = adr[2:0];
    #1;
    val = regRdata;
  endtask

  task automatic rdStat(output int val);
    regAddr = 3'd5;
    regRd = 1'b1;
    #1;
    val = regRdata;
    step();
    regRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) step();
    tick = 1'b0;
  endtask

  task automatic setLine(input int idx, input logic v);
    if (idx == 0) pinBIn = v;
    else xcIn[idx-1] = v;
  endtask

  function automatic int mk(int wm, int stp, int dis, int edg, int src, int trg,
                            int aRa, int aRc, int aEv, int aSw,
                            int bRb, int bRc, int bEv, int bSw);
    return wm | (stp << 2) | (dis << 3) | (edg << 4) | (src << 6) | (trg << 8) |
           (aRa << 9) | (aRc << 11) | (aEv << 13) | (aSw << 15) |
           (bRb << 17) | (bRc << 19) | (bEv << 21) | (bSw << 23);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int v, st, expA, expB, b0, expC;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    chk("R1 outA", outA, 0);
    chk("R1 outB", outB, 0);
    chk("R1 irq", irq, 0);
    peek(0, v); chk("R1 count", v, 0);
    peek(5, v); chk("R1 status", v, 0);
    peek(6, v); chk("R1 mask", v, 0);

    // R2 / R7: mode 0 sweep through wrap
    wr(1, mk(0,0,0,0,0,0, 1,2,0,0, 3,0,0,0));
    wr(2, 10); wr(3, 20); wr(4, 30);
    wr(0, 5);
    expA = 0; expB = 0;
    tick = 1'b1;
    for (int k = 1; k <= 70; k++) begin
      step();
      expC = (k - 1) % 64;
      if (expC == 10) expA = 1;
      if (expC == 30) expA = 0;
      if (expC == 20) expB = 1 - expB;
      peek(0, v); chk("R2 count", v, expC);
      chk("R7 outA", outA, expA);
      chk("R7 outB", outB, expB);
    end
    tick = 1'b0;

    // R11 / R10
    wr(6, 1);
    chk("R11 irq on", irq, 1);
    peek(6, v); chk("R11 mask", v, 1);
    rdStat(st);
    chk("R10 status sticky", st, 32'h1D | (1 << 16) | (1 << 18));
    chk("R11 irq after clear", irq, 0);
    peek(5, v); chk("R10 status cleared", v, (1 << 16) | (1 << 18));
    wr(6, 255);
    peek(6, v); chk("R11 mask valid bits", v, 32'h9D);
    wr(7, 32'h1C);
    peek(6, v); chk("R11 partial disable", v, 32'h81);
    wr(7, 255);
    peek(6, v); chk("R11 mask cleared", v, 0);

    // R3: mode 2 reload at RC
    wr(1, mk(2,0,0,0,0,0, 0,0,0,0, 0,0,0,0));
    wr(4, 12);
    wr(0, 5);
    tick = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      step();
      peek(0, v); chk("R3 count", v, (k - 1) % 13);
    end
    tick = 1'b0;
    rdStat(st);
    chk("R2 no overflow in mode 2", st & 1, 0);

    // R4: mode 1 up/down over full range
    wr(1, mk(1,0,0,0,0,0, 0,0,0,0, 0,0,0,0));
    wr(0, 5);
    tick = 1'b1;
    for (int k = 1; k <= 130; k++) begin
      int p;
      step();
      p = (k - 1) % 126;
      peek(0, v); chk("R4 count updown max", v, (p <= 63) ? p : 126 - p);
    end
    tick = 1'b0;
    rdStat(st);
    chk("R2 overflow at turn", st & 1, 1);

    // R4: mode 3 turns at RC
    wr(1, mk(3,0,0,0,0,0, 0,0,0,0, 0,0,0,0));
    wr(4, 9);
    wr(0, 5);
    tick = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      int p;
      step();
      p = (k - 1) % 18;
      peek(0, v); chk("R4 count updown rc", v, (p <= 9) ? p : 18 - p);
    end
    tick = 1'b0;

    // R6: stop on RC
    wr(1, mk(0,1,0,0,0,0, 0,0,0,0, 0,0,0,0));
    wr(4, 7);
    wr(0, 5);
    tick = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      step();
      peek(0, v); chk("R6 stop count", v, (k - 1 < 7) ? k - 1 : 7);
    end
    tick = 1'b0;
    peek(5, v); chk("R6 clock stays on", (v >> 16) & 1, 1);
    wr(0, 4);
    peek(0, v); chk("R5 trigger waits for tick", v, 7);
    ticks(3);
    peek(0, v); chk("R5 restart after trigger", v, 2);

    // R6: disable on RC
    wr(1, mk(0,0,1,0,0,0, 0,0,0,0, 0,0,0,0));
    wr(4, 5);
    wr(0, 5);
    tick = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      step();
      peek(0, v); chk("R6 disable count", v, (k - 1 < 5) ? k - 1 : 5);
    end
    tick = 1'b0;
    peek(5, v); chk("R6 clock off", (v >> 16) & 1, 0);
    wr(0, 1);
    peek(5, v); chk("R5 enable cmd", (v >> 16) & 1, 1);
    ticks(1);
    peek(0, v); chk("R6 resume", v, 6);
    wr(0, 3);
    peek(5, v); chk("R5 disable wins", (v >> 16) & 1, 0);
    ticks(1);
    peek(0, v); chk("R5 no count when off", v, 6);

    // R9 / R8: software vs event on A
    wr(1, mk(0,0,0,1,1,0, 0,0,2,1, 0,0,0,3));
    b0 = outB;
    rdStat(st);
    xcIn[0] = 1'b1;
    wr(0, 4);
    chk("R9 sw beats event", outA, 1);
    chk("R7 sw toggle B", outB, 1 - b0);
    xcIn[0] = 1'b0;
    step();
    chk("R8 falling ignored", outA, 1);
    xcIn[0] = 1'b1;
    step();
    chk("R8 rising clears A", outA, 0);
    xcIn[0] = 1'b0;
    rdStat(st);
    chk("R8 event status bit", (st >> 7) & 1, 1);

    // R8: source x edge sweep on B
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        int rT, fT, o;
        wr(1, mk(0,0,0,e,s,0, 0,0,0,0, 0,0,3,0));
        b0 = outB;
        rT = e & 1;
        fT = (e >> 1) & 1;
        o = (s + 1) % 4;
        setLine(o, 1'b1); step();
        setLine(o, 1'b0); step();
        chk("R8 other source ignored", outB, b0);
        setLine(s, 1'b1); step();
        chk("R8 rise", outB, b0 ^ rT);
        setLine(s, 1'b0); step();
        chk("R8 fall", outB, b0 ^ rT ^ fT);
      end
    end

    // R8: event as trigger
    wr(1, mk(0,0,0,1,3,1, 0,0,0,0, 0,0,0,0));
    wr(0, 5);
    ticks(5);
    peek(0, v); chk("R5 count before event", v, 4);
    xcIn[2] = 1'b1; step(); xcIn[2] = 1'b0;
    peek(0, v); chk("R8 trigger waits for tick", v, 4);
    ticks(1);
    peek(0, v); chk("R8 event trigger zeroes", v, 0);
    ticks(1);
    peek(0, v); chk("R8 counting resumes", v, 1);

    // R9: RC over RA, non-zero action rule on B
    wr(1, mk(0,0,0,0,0,0, 1,2,0,1, 1,0,0,2));
    wr(2, 3); wr(3, 3); wr(4, 3);
    wr(0, 5);
    chk("R7 sw set A", outA, 1);
    chk("R7 sw clear B", outB, 0);
    ticks(4);
    peek(0, v); chk("R9 count at match", v, 3);
    chk("R9 RC beats RA", outA, 0);
    chk("R9 RB acts when RC none", outB, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule